// File: doc/BRIEF.md
# Presettable BCD Time-of-Day Counter

This block holds the running time of day as six binary-coded decimal digits: hour tens, hour units, minute tens, minute units, second tens and second units. Each cycle in which the one-second enable is high moves the time forward by one second. The carry passes from digit to digit. Each digit has its own wrap limit, and the whole count returns to midnight after the last second of the day.

A separate time-setting block supplies a six-digit preset. A press of the load key copies that preset into the running digits in one step. The key input is brought into the clock domain and edge-detected, so one press loads exactly once. Any preset digit outside its legal range is forced to the nearest legal time before it is stored. The six digits drive the display multiplexer and the alarm comparator directly.

Top module: `tod_bcd_counter`

## Requirements
- R1: A synchronous active-high reset sets all six digits to zero. Both `time_o` and `preset_i` pack the digits as follows: hour tens in [23:20], hour units in [19:16], minute tens in [15:12], minute units in [11:8], second tens in [7:4] and second units in [3:0].
- R2: Each clock edge with `tick_i` high and no load adds one second. Second units count from 0 to 9, and a tick at 9 returns them to 0 and carries into second tens.
- R3: Second tens and minute tens count from 0 to 5. A tick at xx:xx:59 gives seconds 00 and adds one minute. A tick at xx:59:59 gives minutes 00 and adds one hour.
- R4: Hour units wrap from 9 to 0 and increment hour tens, except when hour tens is 2, where they wrap after 3. A tick at 23:59:59 gives 00:00:00.
- R5: With `tick_i` low and no load pending, the time does not change.
- R6: A rising edge on `load_key_i` loads the preset. With the default two synchroniser stages, the loaded value appears on `time_o` after the third rising clock edge that follows the key going high.
- R7: When a load and a tick fall on the same clock edge, the preset is stored and the tick is discarded.
- R8: Holding the key high loads only once. Releasing the key loads nothing.
- R9: The preset is clamped on load as follows:
  - An hour above 23 becomes 23. This covers hour tens of 3 or more, and hour tens of 2 with hour units above 3.
  - Any other hour units digit above 9 becomes 9.
  - A tens digit of minutes or seconds above 5 becomes 5.
  - A units digit of minutes or seconds above 9 becomes 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-second enable, one clock wide per second |
| load_key_i | input | 1 | Load key, debounced but asynchronous |
| preset_i | input | 24 | Six-digit preset from the time-setting logic |
| time_o | output | 24 | Current six-digit time |

## Verification
The assertions make three assumptions about the inputs:
- The load key is already debounced, and each level of it lasts longer than the synchroniser depth plus one cycle, so every press gives exactly one internal load pulse.
- The tick may arrive on any cycle, including the load cycle.
- The preset may hold any 24-bit pattern, because the clamp is what keeps the stored digits legal.

The stimulus respects the key assumption by holding the key level for at least four cycles in each state. It feeds deliberately illegal digit codes on the preset bus. It also drives the tick high on every cycle for a complete day starting from midnight, so every carry and rollover point is visited.

// File: rtl/tod_pkg.sv
package tod_pkg;
   localparam int DIGIT_W   = 4;
   localparam int NUM_DIG   = 6;
   localparam int TIME_W    = DIGIT_W * NUM_DIG;
   localparam int UNITS_MAX = 9;
   localparam int TENS_MAX  = 5;
   localparam int HOUR_T_MAX = 2;
   localparam int HOUR_U_LAST = 3;

   typedef logic [DIGIT_W-1:0] digit_t;

   typedef struct packed {
      digit_t hr_t;
      digit_t hr_u;
      digit_t mn_t;
      digit_t mn_u;
      digit_t sc_t;
      digit_t sc_u;
   } tod_time_t;
endpackage

// File: rtl/tod_key_sync.sv
module tod_key_sync #(
   parameter int STAGES     = 2,
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic key_i,
   output logic press_o
);
   initial assert (STAGES >= 2) else $error("tod_key_sync: STAGES must be at least 2");

   logic             key_lvl;
   logic [STAGES-1:0] sync_q;
   logic             prev_q;

   generate
      if (ACTIVE_LOW) begin : g_inv
         assign key_lvl = ~key_i;
      end else begin : g_dir
         assign key_lvl = key_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], key_lvl};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign press_o = sync_q[STAGES-1] & ~prev_q;

   assert_single_press_R8: assert property (@(posedge clk) disable iff (rst)
      press_o |=> !press_o);
endmodule

// File: rtl/tod_preset_clamp.sv
module tod_preset_clamp
   import tod_pkg::*;
(
   input  tod_time_t raw_i,
   output tod_time_t legal_o
);
   function automatic digit_t cap(input digit_t d, input int lim);
      return (d > digit_t'(lim)) ? digit_t'(lim) : d;
   endfunction

   logic hour_over;

   always_comb begin
      hour_over = (raw_i.hr_t > digit_t'(HOUR_T_MAX)) ||
                  ((raw_i.hr_t == digit_t'(HOUR_T_MAX)) && (raw_i.hr_u > digit_t'(HOUR_U_LAST)));
      if (hour_over) begin
         legal_o.hr_t = digit_t'(HOUR_T_MAX);
         legal_o.hr_u = digit_t'(HOUR_U_LAST);
      end else begin
         legal_o.hr_t = raw_i.hr_t;
         legal_o.hr_u = cap(raw_i.hr_u, UNITS_MAX);
      end
      legal_o.mn_t = cap(raw_i.mn_t, TENS_MAX);
      legal_o.mn_u = cap(raw_i.mn_u, UNITS_MAX);
      legal_o.sc_t = cap(raw_i.sc_t, TENS_MAX);
      legal_o.sc_u = cap(raw_i.sc_u, UNITS_MAX);
   end
endmodule

// File: rtl/tod_digit.sv
module tod_digit
   import tod_pkg::*;
#(
   parameter int LIMIT = 9
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   load_i,
   input  digit_t load_val_i,
   input  logic   inc_i,
   output digit_t q_o,
   output logic   wrap_o
);
   initial assert (LIMIT > 0 && LIMIT <= UNITS_MAX) else $error("tod_digit: LIMIT out of range");

   localparam digit_t LIM = digit_t'(LIMIT);

   always_ff @(posedge clk) begin
      if (rst)          q_o <= '0;
      else if (load_i)  q_o <= load_val_i;
      else if (inc_i)   q_o <= (q_o == LIM) ? '0 : q_o + digit_t'(1);
   end

   assign wrap_o = inc_i & (q_o == LIM);

   assert_digit_limit_R3: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> (q_o <= LIM));
endmodule

// File: rtl/tod_hour_pair.sv
module tod_hour_pair
   import tod_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   load_i,
   input  digit_t load_t_i,
   input  digit_t load_u_i,
   input  logic   inc_i,
   output digit_t tens_o,
   output digit_t units_o
);
   logic last_hour;
   assign last_hour = (tens_o == digit_t'(HOUR_T_MAX)) && (units_o == digit_t'(HOUR_U_LAST));

   always_ff @(posedge clk) begin
      if (rst) begin
         tens_o  <= '0;
         units_o <= '0;
      end else if (load_i) begin
         tens_o  <= load_t_i;
         units_o <= load_u_i;
      end else if (inc_i) begin
         if (last_hour) begin
            tens_o  <= '0;
            units_o <= '0;
         end else if (units_o == digit_t'(UNITS_MAX)) begin
            tens_o  <= tens_o + digit_t'(1);
            units_o <= '0;
         end else begin
            units_o <= units_o + digit_t'(1);
         end
      end
   end

   assert_hour_legal_R4: assert property (@(posedge clk) disable iff (rst)
      (tens_o <= digit_t'(HOUR_T_MAX)) &&
      !((tens_o == digit_t'(HOUR_T_MAX)) && (units_o > digit_t'(HOUR_U_LAST))));
endmodule

// File: rtl/tod_bcd_counter.sv
module tod_bcd_counter
   import tod_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter bit KEY_ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_i,
   input  logic              load_key_i,
   input  logic [TIME_W-1:0] preset_i,
   output logic [TIME_W-1:0] time_o
);
   localparam int PAIRS = 2;

   logic      load_p;
   tod_time_t legal;
   tod_time_t cur;

   tod_key_sync #(.STAGES(SYNC_STAGES), .ACTIVE_LOW(KEY_ACTIVE_LOW)) u_key (
      .clk(clk), .rst(rst), .key_i(load_key_i), .press_o(load_p));

   tod_preset_clamp u_clamp (.raw_i(tod_time_t'(preset_i)), .legal_o(legal));

   digit_t ld_u [PAIRS];
   digit_t ld_t [PAIRS];
   digit_t q_u  [PAIRS];
   digit_t q_t  [PAIRS];
   logic   cin  [PAIRS+1];
   logic   wr_u [PAIRS];

   assign ld_u[0] = legal.sc_u;
   assign ld_t[0] = legal.sc_t;
   assign ld_u[1] = legal.mn_u;
   assign ld_t[1] = legal.mn_t;
   assign cin[0]  = tick_i & ~load_p;

   genvar g;
   generate
      for (g = 0; g < PAIRS; g++) begin : g_pair
         tod_digit #(.LIMIT(UNITS_MAX)) u_units (
            .clk(clk), .rst(rst), .load_i(load_p), .load_val_i(ld_u[g]),
            .inc_i(cin[g]), .q_o(q_u[g]), .wrap_o(wr_u[g]));
         tod_digit #(.LIMIT(TENS_MAX)) u_tens (
            .clk(clk), .rst(rst), .load_i(load_p), .load_val_i(ld_t[g]),
            .inc_i(wr_u[g]), .q_o(q_t[g]), .wrap_o(cin[g+1]));
      end
   endgenerate

   tod_hour_pair u_hours (
      .clk(clk), .rst(rst), .load_i(load_p), .load_t_i(legal.hr_t),
      .load_u_i(legal.hr_u), .inc_i(cin[PAIRS]),
      .tens_o(cur.hr_t), .units_o(cur.hr_u));

   assign cur.sc_u = q_u[0];
   assign cur.sc_t = q_t[0];
   assign cur.mn_u = q_u[1];
   assign cur.mn_t = q_t[1];
   assign time_o   = cur;

   assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
      (!tick_i && !load_p) |=> $stable(time_o));
   assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
      load_p |=> (time_o == $past(legal)));
   assert_second_carry_R2: assert property (@(posedge clk) disable iff (rst)
      (tick_i && !load_p && cur.sc_u == digit_t'(UNITS_MAX)) |=> (time_o[3:0] == '0));
   assert_day_wrap_R4: assert property (@(posedge clk) disable iff (rst)
      (tick_i && !load_p && time_o == 24'h235959) |=> (time_o == '0));
endmodule

// File: tb/tod_bcd_counter_tb.sv
module tod_bcd_counter_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick_i = 1'b0;
   logic        load_key_i = 1'b0;
   logic [23:0] preset_i = '0;
   logic [23:0] time_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tod_bcd_counter dut_i (.clk(clk), .rst(rst), .tick_i(tick_i),
      .load_key_i(load_key_i), .preset_i(preset_i), .time_o(time_o));

   function automatic logic [23:0] to_bcd(input int s);
      int h = (s / 3600) % 24, m = (s / 60) % 60, c = s % 60;
      return {4'(h/10), 4'(h%10), 4'(m/10), 4'(m%10), 4'(c/10), 4'(c%10)};
   endfunction

   function automatic logic [23:0] clamp(input logic [23:0] p);
      logic [3:0] ht = p[23:20], hu = p[19:16];
      logic [23:0] r;
      if (ht > 2 || (ht == 2 && hu > 3)) r[23:16] = 8'h23;
      else r[23:16] = {ht, (hu > 9) ? 4'd9 : hu};
      r[15:12] = (p[15:12] > 5) ? 4'd5 : p[15:12];
      r[11:8]  = (p[11:8]  > 9) ? 4'd9 : p[11:8];
      r[7:4]   = (p[7:4]   > 5) ? 4'd5 : p[7:4];
      r[3:0]   = (p[3:0]   > 9) ? 4'd9 : p[3:0];
      return r;
   endfunction

   task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: time_o=%06h expected %06h", req, got, exp);
      end
   endtask

   task automatic press(input logic [23:0] p, input bit with_tick);
      @(negedge clk); preset_i = p; load_key_i = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk); tick_i = with_tick;
      @(posedge clk);
      @(negedge clk); tick_i = 1'b0;
   endtask

   task automatic release_key();
      @(negedge clk); load_key_i = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic one_tick();
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
   endtask

   initial begin
      preset_i = 24'h123456;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      check("R1 reset", time_o, 24'h000000);

      // full day from midnight, tick every cycle
      @(negedge clk); tick_i = 1'b1;
      for (int i = 1; i <= 86400; i++) begin
         @(negedge clk);
         if (i % 86400 == 0)   check("R4 day wrap", time_o, to_bcd(0));
         else if (i % 60 == 0) check("R3 carry", time_o, to_bcd(i));
         else                  check("R2 count", time_o, to_bcd(i));
      end
      tick_i = 1'b0;
      repeat (20) @(negedge clk);
      check("R5 idle hold", time_o, 24'h000000);

      press(24'h123456, 1'b0);
      check("R6 load", time_o, 24'h123456);
      preset_i = 24'h010101;
      repeat (6) @(negedge clk);
      check("R8 held key", time_o, 24'h123456);
      release_key();
      check("R8 release", time_o, 24'h123456);

      for (int k = 0; k < 3; k++) begin
         one_tick();
         @(negedge clk); @(negedge clk);
         check("R2 sparse tick", time_o, 24'h123457 + 24'(k));
      end

      press(24'h235959, 1'b0); release_key();
      one_tick(); check("R4 midnight", time_o, 24'h000000);
      press(24'h095959, 1'b0); release_key();
      one_tick(); check("R4 hour units 9", time_o, 24'h100000);
      press(24'h195959, 1'b0); release_key();
      one_tick(); check("R4 to twenty", time_o, 24'h200000);
      press(24'h225959, 1'b0); release_key();
      one_tick(); check("R4 to 23", time_o, 24'h230000);
      press(24'h105959, 1'b0); release_key();
      one_tick(); check("R3 minute wrap", time_o, 24'h110000);

      press(24'h010203, 1'b1);
      check("R7 load beats tick", time_o, 24'h010203);
      release_key();
      one_tick(); check("R7 next tick", time_o, 24'h010204);

      begin
         logic [23:0] pats [7] = '{24'h250000, 24'h2F1234, 24'h390000,
                                   24'h0A0000, 24'h127000, 24'h00000C, 24'hFFFFFF};
         for (int j = 0; j < 7; j++) begin
            press(pats[j], 1'b0);
            check("R9 clamp", time_o, clamp(pats[j]));
            release_key();
         end
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: time_o=%06h expected completion", time_o);
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule